// File: doc/BRIEF.md
# Dual Timer Bus Shell

This block is the bus-facing shell that sits in front of a pair of identical down-counting timer channels. It takes zero-wait-state APB accesses in a 4 KB window and decodes each one. Channel register accesses are passed on to the addressed channel through a one-hot write strobe, a register slot index and a read-data return path. The block itself holds an integration-test control bit and a test output vector, and it answers reads of a fixed bank of identification bytes near the top of the window.

The channels report their masked interrupt status to the shell. The shell registers this status onto one interrupt output per channel and drives a combined interrupt that is the OR of those outputs. In integration-test mode, the per-channel outputs are taken from the test output vector instead of from the channels. This lets a system test toggle each interrupt line without running a counter. The counting logic lives in the channel blocks and is outside this block.

Top module: `dualtmr_apb_shell`

## Requirements
- R1: Each channel occupies a 32-byte window, and channel n starts at n*0x20, so address bit 5 selects between the two channels. An access-phase write (psel, penable and pwrite all high) to slot 0 (0x00), 1 (0x04), 2 (0x08), 3 (0x0C) or 6 (0x18) of a channel raises only that channel's bit of `chan_wr_sel` during that access phase. In the same phase, `chan_slot` carries the slot number (address bits 4:2) and `chan_wdata` carries pwdata.
- R2: Writes to channel slots 4 (0x10), 5 (0x14) and 7 (0x1C), and writes to any unmapped offset, raise no strobe. They also leave the test registers unchanged.
- R3: A read of channel slot 0, 1, 2, 4, 5 or 6 returns the addressed channel's `chan_rd_data` word for the slot on `chan_slot`. Reads of slots 3 and 7 return zero.
- R4: Reads of words 0xFD0 through 0xFFC return, in address order, 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0, with all higher bits zero.
- R5: Every other offset reads as zero. Address bits 1:0 are ignored by all decoding.
- R6: Bit 0 of the test control word at 0xF00 is writable and reads back in bit 0, with the other bits reading zero. The test output word at 0xF04 is writable (bit i belongs to channel i) and always reads as zero.
- R7: When test control bit 0 is clear, `irq_ch[i]` equals the value that `chan_irq[i]` had at the previous clock edge.
- R8: When test control bit 0 is set, `irq_ch[i]` equals the value that test output bit i had at the previous clock edge, and `chan_irq` has no effect.
- R9: `irq_comb` is high exactly when any bit of `irq_ch` is high, in both modes.
- R10: Reset clears the test control and test output words and drives all interrupt outputs low.
- R11: `pready` is always high and `pslverr` is always low. No strobe is raised during a setup phase or during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address within the window |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| chan_wr_sel | output | NCH | One-hot write strobe, one bit per channel |
| chan_slot | output | 3 | Register slot within the channel window |
| chan_wdata | output | DATA_W | Write data to the channels |
| chan_rd_data | input | NCH*DATA_W | Channel read words, channel 0 in the low bits |
| chan_irq | input | NCH | Masked interrupt status from each channel |
| irq_ch | output | NCH | Registered per-channel interrupts |
| irq_comb | output | 1 | Registered combined interrupt |

## Verification
The bench sweeps every word of the window for both reads and writes, with junk placed in the low address bits.

- A decoder that took bit 5 wrong, or forwarded a strobe for a status slot, would send a write to the wrong channel or commit it into read-only state.
- A decoder with an off-by-one ID offset would shift the identification bytes.

All sixteen combinations of test bits and channel status are applied in both modes:

- An override that leaked channel status while in test mode would show up in these combinations.
- So would an OR that ignored one line.

A reset asserted while test mode is driving the lines must drop them at once.

// File: rtl/dualtmr_pkg.sv
package dualtmr_pkg;

   localparam int unsigned WIN_AW = 12;
   localparam int unsigned WORD_AW = WIN_AW - 2;

   // word addresses (byte address >> 2)
   localparam logic [WORD_AW-1:0] WORD_TCTRL = 10'h3C0;
   localparam logic [WORD_AW-1:0] WORD_TOUT  = 10'h3C1;
   localparam logic [WORD_AW-1:0] WORD_ID_LO = 10'h3F4;
   localparam int unsigned        ID_COUNT   = 12;

   typedef enum logic [2:0] {
      SLOT_LOAD   = 3'd0,
      SLOT_VALUE  = 3'd1,
      SLOT_CTRL   = 3'd2,
      SLOT_CLR    = 3'd3,
      SLOT_RAW    = 3'd4,
      SLOT_MASKED = 3'd5,
      SLOT_BGLOAD = 3'd6,
      SLOT_SPARE  = 3'd7
   } slot_e;

   typedef enum logic [2:0] {
      RGN_CHAN,
      RGN_TCTRL,
      RGN_TOUT,
      RGN_ID,
      RGN_NONE
   } region_e;

   function automatic logic [7:0] id_byte(input logic [3:0] k);
      case (k)
         4'd0:    id_byte = 8'h04;
         4'd4:    id_byte = 8'h23;
         4'd5:    id_byte = 8'hB8;
         4'd6:    id_byte = 8'h1B;
         4'd8:    id_byte = 8'h0D;
         4'd9:    id_byte = 8'hF0;
         4'd10:   id_byte = 8'h05;
         4'd11:   id_byte = 8'hB1;
         default: id_byte = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/dualtmr_decode.sv
module dualtmr_decode
   import dualtmr_pkg::*;
#(
   parameter int NCH  = 2,
   parameter int CH_W = 1
) (
   input  logic [WORD_AW-1:0] word,
   output region_e            region,
   output logic [CH_W-1:0]    chan,
   output slot_e              slot,
   output logic               wr_ok,
   output logic               rd_ok
);

   logic [WORD_AW-4:0] chan_field;

   assign chan_field = word[WORD_AW-1:3];
   assign chan       = chan_field[CH_W-1:0];
   assign slot       = slot_e'(word[2:0]);

   always_comb begin
      if (int'(chan_field) < NCH)   region = RGN_CHAN;
      else if (word == WORD_TCTRL)  region = RGN_TCTRL;
      else if (word == WORD_TOUT)   region = RGN_TOUT;
      else if (word >= WORD_ID_LO)  region = RGN_ID;
      else                          region = RGN_NONE;
   end

   always_comb begin
      wr_ok = 1'b0;
      rd_ok = 1'b0;
      case (slot)
         SLOT_LOAD, SLOT_VALUE, SLOT_CTRL, SLOT_BGLOAD: begin
            wr_ok = 1'b1;
            rd_ok = 1'b1;
         end
         SLOT_CLR:               wr_ok = 1'b1;
         SLOT_RAW, SLOT_MASKED:  rd_ok = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/dualtmr_idrom.sv
module dualtmr_idrom
   import dualtmr_pkg::*;
(
   input  logic [3:0] word_lo,
   output logic [7:0] id_val
);

   logic [3:0] idx;

   // bank starts at word low nibble 4 and ends at F
   assign idx    = word_lo - 4'h4;
   assign id_val = id_byte(idx);

endmodule

// File: rtl/dualtmr_irq.sv
module dualtmr_irq #(
   parameter int NCH     = 2,
   parameter bit TEST_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           test_mode,
   input  logic [NCH-1:0] test_bits,
   input  logic [NCH-1:0] chan_irq,
   output logic [NCH-1:0] irq_ch,
   output logic           irq_comb
);

   logic [NCH-1:0] pick;

   generate
      if (TEST_EN) begin : g_override
         assign pick = test_mode ? test_bits : chan_irq;
      end else begin : g_direct
         logic unused_test;
         assign unused_test = test_mode ^ (^test_bits);
         assign pick = chan_irq;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_ch   <= '0;
         irq_comb <= 1'b0;
      end else begin
         irq_ch   <= pick;
         irq_comb <= |pick;
      end
   end

   p_irq_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !test_mode |=> irq_ch == $past(chan_irq))
      else $error("R7 normal-mode interrupt mismatch");

   p_irq_test_r8: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |=> irq_ch == $past(test_bits))
      else $error("R8 test-mode interrupt mismatch");

   p_irq_comb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_comb == (|irq_ch))
      else $error("R9 combined interrupt mismatch");

endmodule

// File: rtl/dualtmr_apb_shell.sv
module dualtmr_apb_shell
   import dualtmr_pkg::*;
#(
   parameter int NCH     = 2,
   parameter int DATA_W  = 32,
   parameter bit TEST_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  psel,
   input  logic                  penable,
   input  logic                  pwrite,
   input  logic [11:0]           paddr,
   input  logic [DATA_W-1:0]     pwdata,
   output logic [DATA_W-1:0]     prdata,
   output logic                  pready,
   output logic                  pslverr,
   output logic [NCH-1:0]        chan_wr_sel,
   output logic [2:0]            chan_slot,
   output logic [DATA_W-1:0]     chan_wdata,
   input  logic [NCH*DATA_W-1:0] chan_rd_data,
   input  logic [NCH-1:0]        chan_irq,
   output logic [NCH-1:0]        irq_ch,
   output logic                  irq_comb
);

   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

   generate
      if (NCH < 1 || NCH * 32 > 'hF00) begin : g_bad_nch
         $error("NCH must fit below the test registers");
      end
      if (DATA_W < 8 || DATA_W < NCH) begin : g_bad_width
         $error("DATA_W must hold an ID byte and one test bit per channel");
      end
   endgenerate

   region_e           region;
   slot_e             slot;
   logic [CH_W-1:0]   chan;
   logic              wr_ok, rd_ok;
   logic [7:0]        id_val;
   logic              wr_acc, rd_acc;
   logic              test_mode;
   logic [NCH-1:0]    test_bits;
   logic [DATA_W-1:0] rd_arr [NCH];
   logic [DATA_W-1:0] rdata;
   logic [1:0]        unused_lo;

   assign unused_lo = paddr[1:0];
   assign pready    = 1'b1;
   assign pslverr   = 1'b0;
   assign wr_acc    = psel & penable & pwrite;
   assign rd_acc    = psel & ~pwrite;

   dualtmr_decode #(.NCH(NCH), .CH_W(CH_W)) u_decode (
      .word   (paddr[11:2]),
      .region (region),
      .chan   (chan),
      .slot   (slot),
      .wr_ok  (wr_ok),
      .rd_ok  (rd_ok)
   );

   dualtmr_idrom u_idrom (
      .word_lo (paddr[5:2]),
      .id_val  (id_val)
   );

   assign chan_slot  = slot;
   assign chan_wdata = pwdata;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_chan
         assign chan_wr_sel[i] = wr_acc && region == RGN_CHAN && wr_ok
                                 && int'(chan) == i;
         assign rd_arr[i]      = chan_rd_data[i*DATA_W +: DATA_W];
      end
   endgenerate

   always_comb begin
      rdata = '0;
      case (region)
         RGN_CHAN:  if (rd_ok) rdata = rd_arr[chan];
         RGN_TCTRL: rdata[0] = test_mode;
         RGN_ID:    rdata[7:0] = id_val;
         default: ;
      endcase
   end

   assign prdata = rd_acc ? rdata : '0;

   generate
      if (TEST_EN) begin : g_test
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               test_mode <= 1'b0;
               test_bits <= '0;
            end else if (wr_acc) begin
               if (region == RGN_TCTRL) test_mode <= pwdata[0];
               if (region == RGN_TOUT)  test_bits <= pwdata[NCH-1:0];
            end
         end

         p_test_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_acc && (region == RGN_TCTRL || region == RGN_TOUT))
               |=> $stable(test_bits) && $stable(test_mode))
            else $error("R2 test register changed without a write");
      end else begin : g_no_test
         assign test_mode = 1'b0;
         assign test_bits = '0;
      end
   endgenerate

   dualtmr_irq #(.NCH(NCH), .TEST_EN(TEST_EN)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .test_mode (test_mode),
      .test_bits (test_bits),
      .chan_irq  (chan_irq),
      .irq_ch    (irq_ch),
      .irq_comb  (irq_comb)
   );

   p_wr_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_wr_sel))
      else $error("R1 more than one channel strobed");

   p_no_stray_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(psel && penable && pwrite) |-> chan_wr_sel == '0)
      else $error("R11 strobe outside a write access phase");

endmodule

// File: tb/dualtmr_apb_shell_tb_top.sv
module dualtmr_apb_shell_tb_top;

   localparam int NCH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic [1:0]  chan_wr_sel;
   logic [2:0]  chan_slot;
   logic [31:0] chan_wdata;
   logic [63:0] chan_rd_data;
   logic [1:0]  chan_irq = '0;
   logic [1:0]  irq_ch;
   logic        irq_comb;

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   // channel model: read word encodes channel and slot
   always_comb begin
      for (int k = 0; k < 2; k++)
         chan_rd_data[k*32 +: 32] = 32'h5A00_0003 | (32'(k) << 20) | (32'(chan_slot) << 4);
   end

   dualtmr_apb_shell #(.NCH(NCH), .DATA_W(32), .TEST_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
      .pslverr(pslverr), .chan_wr_sel(chan_wr_sel), .chan_slot(chan_slot),
      .chan_wdata(chan_wdata), .chan_rd_data(chan_rd_data), .chan_irq(chan_irq),
      .irq_ch(irq_ch), .irq_comb(irq_comb)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_id(input int k);
      logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h23, 8'hB8,
                              8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      return t[k];
   endfunction

   function automatic logic [31:0] exp_rd(input logic [11:0] a, input logic tm);
      int w = int'(a[11:2]);
      int s = int'(a[4:2]);
      if (a[11:6] == 0) begin
         if (s == 3 || s == 7) return 32'h0;
         return 32'h5A00_0003 | (32'(a[5]) << 20) | (32'(s) << 4);
      end
      if (w == 'h3C0) return {31'h0, tm};
      if (w >= 'h3F4) return {24'h0, exp_id(w - 'h3F4)};
      return 32'h0;
   endfunction

   function automatic logic [1:0] exp_sel(input logic [11:0] a);
      int s = int'(a[4:2]);
      if (a[11:6] == 0 && (s <= 3 || s == 6)) return 2'b01 << a[5];
      return 2'b00;
   endfunction

   task automatic apb_write(input logic [11:0] a, input logic [31:0] d, input string req);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
      #1 chk("R11 setup-phase strobe", {30'h0, chan_wr_sel}, 32'h0);
      @(negedge clk);
      penable = 1'b1;
      #1 chk(req, {30'h0, chan_wr_sel}, {30'h0, exp_sel(a)});
      if (exp_sel(a) != 2'b00) begin
         chk("R1 slot", {29'h0, chan_slot}, {29'h0, a[4:2]});
         chk("R1 data", chan_wdata, d);
      end
      @(posedge clk);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_read(input logic [11:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      @(negedge clk);
      penable = 1'b1;
      #1 chk(req, prdata, exp);
      chk("R11 no strobe on read", {30'h0, chan_wr_sel}, 32'h0);
      @(posedge clk);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10 irq_ch in reset", {30'h0, irq_ch}, 32'h0);
      chk("R10 irq_comb in reset", {31'h0, irq_comb}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 pready", {31'h0, pready}, 32'h1);
      chk("R11 pslverr", {31'h0, pslverr}, 32'h0);
      apb_read(12'hF00, 32'h0, "R10 test control after reset");

      // R3 R4 R5: read sweep with junk in low address bits
      for (int w = 0; w < 1024; w++) begin
         logic [11:0] a = {w[9:0], w[1:0]};
         apb_read(a, exp_rd(a, 1'b0), "R3/R4/R5 read sweep");
      end

      // R1 R2: write sweep; test registers get zero so they stay clear
      for (int w = 0; w < 1024; w++) begin
         logic [11:0] a = {w[9:0], w[1:0]};
         logic [31:0] d = (w == 'h3C0 || w == 'h3C1) ? 32'h0 : ~{22'h0, w[9:0]};
         apb_write(a, d, "R1/R2 write strobe sweep");
      end
      apb_read(12'hF00, 32'h0, "R2 test control untouched by other writes");
      chan_irq = 2'b00;
      repeat (2) @(negedge clk);
      chk("R2 irq stays low", {30'h0, irq_ch}, 32'h0);

      // R6 R7 R8 R9: all combinations in both modes
      for (int tm = 0; tm < 2; tm++) begin
         apb_write(12'hF00, 32'hFFFF_FFFE | 32'(tm), "R6 test control write");
         apb_read(12'hF00, 32'(tm), "R6 test control readback");
         for (int t = 0; t < 4; t++) begin
            apb_write(12'hF04, 32'(t), "R6 test output write");
            apb_read(12'hF04, 32'h0, "R6 test output reads zero");
            for (int c = 0; c < 4; c++) begin
               logic [1:0] e;
               chan_irq = c[1:0];
               repeat (2) @(negedge clk);
               e = (tm == 1) ? t[1:0] : c[1:0];
               chk(tm == 1 ? "R8 test-mode irq_ch" : "R7 normal irq_ch",
                   {30'h0, irq_ch}, {30'h0, e});
               chk("R9 irq_comb", {31'h0, irq_comb}, {31'h0, |e});
            end
         end
      end

      // R10: reset while test mode drives the lines
      apb_write(12'hF04, 32'h3, "R6 test output write");
      chan_irq = 2'b00;
      repeat (2) @(negedge clk);
      chk("R8 override before reset", {30'h0, irq_ch}, 32'h3);
      rst_n = 1'b0;
      #1 chk("R10 irq_ch on reset", {30'h0, irq_ch}, 32'h0);
      chk("R10 irq_comb on reset", {31'h0, irq_comb}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      apb_read(12'hF00, 32'h0, "R10 test control cleared");
      repeat (2) @(negedge clk);
      chk("R10 test output cleared", {30'h0, irq_ch}, 32'h0);

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule